// File: doc/BRIEF.md
# Wide Settings Register Write Bridge

The bridge sits behind a 16-bit bus slave and turns pairs of halfword writes into single 32-bit writes on a write-only settings bus. The host addresses the slave with 11-bit byte addresses. Bits [6:2] pick one of 32 settings registers and bit 1 picks which half is being written. Bits [10:7] belong to the slave-select decode outside this block and are ignored here. Bit 0 is ignored because every access is a halfword.

A halfword written with bit 1 clear is kept in a holding register as the low half. A halfword written with bit 1 set is the high half. It fires a one-cycle settings strobe carrying the register index taken from that same write and the data {high half, held low half}. The bridge does not check that both halves name the same register. A mismatched pair goes out with whatever low half was last held. Reads are acknowledged and always return zero.

Top module: `setting_word_bridge`

## Requirements
- R1: `bus_ack_o` rises exactly one cycle after a strobe is sampled, for both reads and writes, and stays high for a single cycle even when `bus_stb_i` is held high.
- R2: `bus_dat_o` is zero at all times.
- R3: A write with address bit 1 = 0 (first half) stores `bus_dat_i` as the low half and produces no settings strobe.
- R4: A write with address bit 1 = 1 (second half) drives `set_stb_o` high for exactly one cycle, one cycle after the bus strobe. `set_addr_o` is address bits [6:2] zero-extended, and `set_data_o` is {that write's data, held low half}.
- R5: A second-half write to an index different from the preceding first-half write still fires. It uses its own index and the stale held low half.
- R6: A read (`bus_we_i` = 0) produces no settings strobe and leaves the held low half unchanged.
- R7: While `rst_ni` is low, `bus_ack_o` and `set_stb_o` are 0 and the held low half is cleared. A second-half write that follows reset therefore carries low half 0x0000.
- R8: Address bits [10:7] and bit 0 have no effect on the register index or the half selection.
- R9: The held low half persists across any number of second-half writes, so repeated high-half writes reuse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_stb_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable (1 = write) |
| bus_adr_i | input | 11 | Byte address |
| bus_dat_i | input | 16 | Write data halfword |
| bus_ack_o | output | 1 | Access acknowledge |
| bus_dat_o | output | 16 | Read data (always zero) |
| set_stb_o | output | 1 | Settings write strobe |
| set_addr_o | output | 8 | Settings register index |
| set_data_o | output | 32 | Settings register value |

## Verification
The acknowledge and the settings strobe, address and data each pass through one register. Each is due at the first clock edge after the bus strobe is sampled. The bench drives inputs on the falling edge and lowers the strobe one cycle later. It samples every result at that next falling edge, then checks one cycle further on that acknowledge and settings strobe have dropped again. Accesses that must not fire, meaning reads and first halves, are checked at the same sample point for a low settings strobe. Any disturbance of the held low half is exposed by the data of the next second-half write.

// File: rtl/swb_pkg.sv
package swb_pkg;
  // Address bit 1 selects which half of a settings word a bus write carries.
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  localparam int unsigned HALF_BIT = 1;
  localparam int unsigned IDX_LSB  = 2;
endpackage

// File: rtl/swb_bus_port.sv
module swb_bus_port
  import swb_pkg::*;
#(
  parameter int unsigned SLOT_W = 7,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = SLOT_W - IDX_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [SLOT_W-1:1] adr_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] dat_o,
  output logic              wr_lo_o,
  output logic              wr_hi_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic  ack_q;
  logic  accept;
  half_e half;

  // A held strobe is consumed once; the cycle carrying ack is not a new access.
  assign accept = stb_i & ~ack_q;
  assign half   = half_e'(adr_i[HALF_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= accept;
  end

  assign ack_o   = ack_q;
  assign dat_o   = '0;
  assign wr_lo_o = accept & we_i & (half == HALF_LO);
  assign wr_hi_o = accept & we_i & (half == HALF_HI);
  assign idx_o   = adr_i[SLOT_W-1:IDX_LSB];
endmodule

// File: rtl/swb_low_hold.sv
module swb_low_hold #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic [DATA_W-1:0] low_o
);
  logic [DATA_W-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_q <= '0;
    else if (load_i) low_q <= dat_i;
  end

  assign low_o = low_q;
endmodule

// File: rtl/swb_emit.sv
module swb_emit #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned SET_ADDR_W = 8,
  localparam int unsigned SET_W     = 2 * DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fire_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [DATA_W-1:0]     hi_i,
  input  logic [DATA_W-1:0]     lo_i,
  output logic                  stb_o,
  output logic [SET_ADDR_W-1:0] addr_o,
  output logic [SET_W-1:0]      data_o
);
  logic                  stb_q;
  logic [SET_ADDR_W-1:0] addr_q;
  logic [SET_W-1:0]      data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      stb_q <= fire_i;
      if (fire_i) begin
        addr_q <= SET_ADDR_W'(idx_i);
        data_q <= {hi_i, lo_i};
      end
    end
  end

  assign stb_o  = stb_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/setting_word_bridge.sv
module setting_word_bridge
  import swb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SLOT_W     = 7,
  parameter int unsigned SET_ADDR_W = 8,
  localparam int unsigned IDX_W     = SLOT_W - IDX_LSB,
  localparam int unsigned SET_W     = 2 * DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_stb_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_adr_i,
  input  logic [DATA_W-1:0]     bus_dat_i,
  output logic                  bus_ack_o,
  output logic [DATA_W-1:0]     bus_dat_o,
  output logic                  set_stb_o,
  output logic [SET_ADDR_W-1:0] set_addr_o,
  output logic [SET_W-1:0]      set_data_o
);
  logic              wr_lo;
  logic              wr_hi;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] low_half;

  // Slave-select bits and the byte bit are decoded elsewhere.
  logic unused_adr_bits;
  assign unused_adr_bits = ^{bus_adr_i[ADDR_W-1:SLOT_W], bus_adr_i[0]};

  swb_bus_port #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (bus_stb_i),
    .we_i    (bus_we_i),
    .adr_i   (bus_adr_i[SLOT_W-1:1]),
    .ack_o   (bus_ack_o),
    .dat_o   (bus_dat_o),
    .wr_lo_o (wr_lo),
    .wr_hi_o (wr_hi),
    .idx_o   (idx)
  );

  swb_low_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_lo),
    .dat_i  (bus_dat_i),
    .low_o  (low_half)
  );

  swb_emit #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SET_ADDR_W(SET_ADDR_W)) u_emit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (wr_hi),
    .idx_i  (idx),
    .hi_i   (bus_dat_i),
    .lo_i   (low_half),
    .stb_o  (set_stb_o),
    .addr_o (set_addr_o),
    .data_o (set_data_o)
  );
endmodule

// File: rtl/setting_word_bridge_chk.sv
module setting_word_bridge_chk #(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SLOT_W     = 7,
  parameter int unsigned SET_ADDR_W = 8,
  localparam int unsigned SET_W     = 2 * DATA_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_stb_i,
  input logic                  bus_we_i,
  input logic [ADDR_W-1:0]     bus_adr_i,
  input logic [DATA_W-1:0]     bus_dat_i,
  input logic                  bus_ack_o,
  input logic [DATA_W-1:0]     bus_dat_o,
  input logic                  set_stb_o,
  input logic [SET_ADDR_W-1:0] set_addr_o,
  input logic [SET_W-1:0]      set_data_o
);
  logic new_acc;
  assign new_acc = bus_stb_i & ~bus_ack_o;

  a_r1_ack_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_acc |=> bus_ack_o);
  a_r1_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |=> !bus_ack_o);
  a_r2_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dat_o == '0);
  a_r3_lo_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_acc && bus_we_i && !bus_adr_i[1]) |=> !set_stb_o);
  a_r4_hi_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_acc && bus_we_i && bus_adr_i[1]) |=> set_stb_o);
  a_r4_hi_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_acc && bus_we_i && bus_adr_i[1]) |=>
      set_addr_o == SET_ADDR_W'($past(bus_adr_i[SLOT_W-1:2])));
  a_r4_hi_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_acc && bus_we_i && bus_adr_i[1]) |=>
      set_data_o[SET_W-1:DATA_W] == $past(bus_dat_i));
  a_r4_set_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_stb_o |-> bus_ack_o);
  a_r6_read_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_stb_i && !bus_we_i) |=> !set_stb_o);
endmodule

bind setting_word_bridge setting_word_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .SET_ADDR_W(SET_ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_stb_i  (bus_stb_i),
  .bus_we_i   (bus_we_i),
  .bus_adr_i  (bus_adr_i),
  .bus_dat_i  (bus_dat_i),
  .bus_ack_o  (bus_ack_o),
  .bus_dat_o  (bus_dat_o),
  .set_stb_o  (set_stb_o),
  .set_addr_o (set_addr_o),
  .set_data_o (set_data_o)
);

// File: tb/setting_word_bridge_bench.sv
module setting_word_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic        we;
    logic [10:0] adr;
    logic [15:0] dat;
    logic        exp_set;
    logic [7:0]  exp_addr;
    logic [31:0] exp_data;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 11'h28A, 16'hBEEF, 1'b1, 8'd2,  32'hBEEF_0000, 8'd7}, // R7 low half is 0 after reset
    '{1'b1, 11'h294, 16'h1234, 1'b0, 8'd0,  32'h0,         8'd3}, // R3 first half, idx 5
    '{1'b1, 11'h296, 16'hABCD, 1'b1, 8'd5,  32'hABCD_1234, 8'd4}, // R4 pair completes
    '{1'b0, 11'h294, 16'hFFFF, 1'b0, 8'd0,  32'h0,         8'd6}, // R6 read is silent
    '{1'b1, 11'h296, 16'h5555, 1'b1, 8'd5,  32'h5555_1234, 8'd9}, // R9 low reused, R6 untouched
    '{1'b1, 11'h28C, 16'h0F0F, 1'b0, 8'd0,  32'h0,         8'd3}, // R3 first half, idx 3
    '{1'b1, 11'h29E, 16'h7777, 1'b1, 8'd7,  32'h7777_0F0F, 8'd5}, // R5 mismatched index
    '{1'b1, 11'h47D, 16'hCAFE, 1'b0, 8'd0,  32'h0,         8'd8}, // R8 high bits, bit0 set
    '{1'b1, 11'h7FF, 16'h0001, 1'b1, 8'd31, 32'h0001_CAFE, 8'd8}, // R8 idx 31 high half
    '{1'b1, 11'h280, 16'hFFFF, 1'b0, 8'd0,  32'h0,         8'd3}, // R3 idx 0
    '{1'b1, 11'h282, 16'h0000, 1'b1, 8'd0,  32'h0000_FFFF, 8'd4}  // R4 idx 0
  };

  logic        clk;
  logic        rst_n;
  logic        stb;
  logic        we;
  logic [10:0] adr;
  logic [15:0] wdat;
  logic        ack;
  logic [15:0] rdat;
  logic        sstb;
  logic [7:0]  saddr;
  logic [31:0] sdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  setting_word_bridge u_setting_word_bridge (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_stb_i  (stb),
    .bus_we_i   (we),
    .bus_adr_i  (adr),
    .bus_dat_i  (wdat),
    .bus_ack_o  (ack),
    .bus_dat_o  (rdat),
    .set_stb_o  (sstb),
    .set_addr_o (saddr),
    .set_data_o (sdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // One access: strobe for a cycle, results sampled at the next falling edge.
  task automatic access(input logic w, input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    stb = 1'b1; we = w; adr = a; wdat = d;
    @(negedge clk);
    stb = 1'b0; we = 1'b0;
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    chk({req, " ack drops"}, 32'(ack), 32'd0);
    chk({req, " set_stb drops"}, 32'(sstb), 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; stb = 1'b0; we = 1'b0; adr = '0; wdat = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 ack in reset", 32'(ack), 32'd0);
    chk("R7 set_stb in reset", 32'(sstb), 32'd0);
    chk("R2 rdata in reset", 32'(rdat), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
      access(TBL[i].we, TBL[i].adr, TBL[i].dat);
      chk({tag, " R1 ack"}, 32'(ack), 32'd1);
      chk({tag, " R2 rdata"}, 32'(rdat), 32'd0);
      chk({tag, " set_stb"}, 32'(sstb), 32'(TBL[i].exp_set));
      if (TBL[i].exp_set) begin
        chk({tag, " set_addr"}, 32'(saddr), 32'(TBL[i].exp_addr));
        chk({tag, " set_data"}, sdata, TBL[i].exp_data);
      end
      idle_check(tag);
    end

    // R1: strobe held two cycles gives one ack and one settings write
    @(negedge clk);
    stb = 1'b1; we = 1'b1; adr = 11'h2A6; wdat = 16'h2222;
    @(negedge clk);
    chk("R1 held stb ack", 32'(ack), 32'd1);
    chk("R1 held stb fires", 32'(sstb), 32'd1);
    chk("R4 held stb addr", 32'(saddr), 32'd9);
    @(negedge clk);
    stb = 1'b0; we = 1'b0;
    chk("R1 held stb single ack", 32'(ack), 32'd0);
    chk("R1 held stb single fire", 32'(sstb), 32'd0);

    // R7: reset mid-run clears the held low half
    access(1'b1, 11'h2A0, 16'h9999);
    chk("R3 low before reset", 32'(sstb), 32'd0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 ack during reset", 32'(ack), 32'd0);
    chk("R7 set_stb during reset", 32'(sstb), 32'd0);
    rst_n = 1'b1;
    access(1'b1, 11'h2A2, 16'h4444);
    chk("R7 post-reset addr", 32'(saddr), 32'd8);
    chk("R7 post-reset low cleared", sdata, 32'h4444_0000);
    idle_check("R7 post-reset");

    done = 1'b1;
    summary();
  end
endmodule